// File: doc/BRIEF.md
# Conditional Load/Store Address Unit

This block carries out one memory transfer, either a 32-bit word or a single byte, for a load or store instruction. It only does so when the instruction's 4-bit condition field passes against the N, Z, C and V flags. It computes the address from a base register value and an offset. The offset is either a 12-bit signed immediate, or a register value shifted by a 5-bit amount that is then added to or subtracted from the base. The addressing mode decides which address reaches memory and whether an updated base goes back to the register file.

A request is taken in one cycle while `req_ready` is high. The unit then runs a short sequence on its own: a memory access with a valid/ready handshake, then the write of the load result, then the base-register write. It accepts nothing else until that whole sequence has finished. If the condition fails, the request is consumed and nothing else happens.

Top module: `ldst_cond_unit`

## Requirements
- R1: The condition codes `req_cond` 0 to 13 test, in this order: Z, !Z, C, !C, N, !N, V, !V, (C & !Z), (!C | Z), (N==V), (N!=V), (!Z & N==V), (Z | N!=V). Code 14 always executes. Code 15 never executes.
- R2: A request whose condition fails causes no memory handshake and no register write, and `req_ready` is high again in the next cycle.
- R3: Mode 0 (pre-offset): the memory address is base plus offset, and the base register is not written.
- R4: Mode 1 (pre-offset with update): the memory address is base plus offset, and that same value is written to register `req_rn`.
- R5: Mode 2 (post-offset): the memory address is the unmodified base, and base plus offset is then written to `req_rn`.
- R6: Mode 3 (PC-relative): the address is `req_pc` plus the sign-extended `req_imm`. `req_use_reg` is ignored and no register is written.
- R7: With `req_use_reg`=0 the offset is `req_imm` as a 12-bit two's-complement value, added to the base. With `req_use_reg`=1 the offset is `req_rm` shifted left (`req_shr`=0) or logically right (`req_shr`=1) by `req_shamt`. It is added when `req_sub`=0 and subtracted when `req_sub`=1.
- R8: A byte load (`req_load`=1, `req_byte`=1) writes to `req_rd` the byte on lane address[1:0], zero-extended to 32 bits. Lane k is `mem_rdata[8k+7:8k]`. A word load writes the whole of `mem_rdata`.
- R9: A byte store drives `mem_be` with only bit address[1:0] set, and puts the low byte of `req_sdata` on all four lanes. A word store drives `mem_be`=4'b1111 and `mem_wdata`=`req_sdata`.
- R10: `mem_valid` stays high with a stable `mem_addr` until `mem_ready` is high. Load data is taken from `mem_rdata` in the cycle after the handshake.
- R11: When a transfer is a load that also updates the base, the loaded data is written to `req_rd` first, and the new base is written to `req_rn` in the following cycle.
- R12: When a load updates the base and `req_rd`==`req_rn`, only the loaded data is written. `base_clash` is high during that write.
- R13: `req_ready` is low from the cycle after acceptance until the sequence ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request taken this cycle |
| req_cond | input | 4 | Condition code |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| req_load | input | 1 | 1 load, 0 store |
| req_byte | input | 1 | 1 byte, 0 word |
| req_mode | input | 2 | 0 pre, 1 pre+update, 2 post, 3 PC-relative |
| req_use_reg | input | 1 | Offset from shifted register |
| req_sub | input | 1 | Subtract register offset |
| req_shr | input | 1 | Shift right instead of left |
| req_shamt | input | 5 | Shift amount |
| req_imm | input | IMM_W | Signed immediate offset |
| req_base | input | 32 | Base register value |
| req_rm | input | 32 | Offset register value |
| req_pc | input | 32 | Current PC |
| req_sdata | input | 32 | Store data |
| req_rd | input | RI_W | Load destination index |
| req_rn | input | RI_W | Base register index |
| mem_valid | output | 1 | Memory request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables |
| mem_ready | input | 1 | Memory accepts request |
| mem_rdata | input | 32 | Read data, one cycle after handshake |
| rf_we | output | 1 | Register write strobe |
| rf_waddr | output | RI_W | Register write index |
| rf_wdata | output | 32 | Register write data |
| base_clash | output | 1 | Base update dropped in favour of loaded data |

## Verification
The bench sweeps all sixteen condition codes across all sixteen flag patterns. A mistake in a compound test such as HI or LE would show up as a missing or extra memory handshake, and a decoder that executed code 15 would show a spurious access. It runs each addressing mode with both positive and negative offsets, and with register offsets in both shift directions. A design that swapped the pre- and post-offset address would put the wrong value either on `mem_addr` or on the base write. Byte loads and stores are driven on every lane, so a wrong lane, missing zero-extension or wrong enable shows up as a data mismatch. A stalled handshake, a load with a base update, and a load whose destination equals its base check, respectively, that the address holds, that the write order is kept, and that a clashing base write is dropped.

// File: rtl/ldst_cond_unit.sv
module ldst_cond_unit #(
  parameter int IMM_W = 12,
  parameter int RI_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [3:0]       req_cond,
  input  logic             flag_n,
  input  logic             flag_z,
  input  logic             flag_c,
  input  logic             flag_v,
  input  logic             req_load,
  input  logic             req_byte,
  input  logic [1:0]       req_mode,
  input  logic             req_use_reg,
  input  logic             req_sub,
  input  logic             req_shr,
  input  logic [4:0]       req_shamt,
  input  logic [IMM_W-1:0] req_imm,
  input  logic [31:0]      req_base,
  input  logic [31:0]      req_rm,
  input  logic [31:0]      req_pc,
  input  logic [31:0]      req_sdata,
  input  logic [RI_W-1:0]  req_rd,
  input  logic [RI_W-1:0]  req_rn,
  output logic             mem_valid,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  output logic [3:0]       mem_be,
  input  logic             mem_ready,
  input  logic [31:0]      mem_rdata,
  output logic             rf_we,
  output logic [RI_W-1:0]  rf_waddr,
  output logic [31:0]      rf_wdata,
  output logic             base_clash
);

  typedef enum logic [1:0] {S_IDLE, S_MEM, S_LDW, S_BWB} st_t;
  st_t st;

  logic cond_ok;
  always_comb begin
    case (req_cond)
      4'd0:    cond_ok = flag_z;
      4'd1:    cond_ok = !flag_z;
      4'd2:    cond_ok = flag_c;
      4'd3:    cond_ok = !flag_c;
      4'd4:    cond_ok = flag_n;
      4'd5:    cond_ok = !flag_n;
      4'd6:    cond_ok = flag_v;
      4'd7:    cond_ok = !flag_v;
      4'd8:    cond_ok = flag_c && !flag_z;
      4'd9:    cond_ok = !flag_c || flag_z;
      4'd10:   cond_ok = flag_n == flag_v;
      4'd11:   cond_ok = flag_n != flag_v;
      4'd12:   cond_ok = !flag_z && (flag_n == flag_v);
      4'd13:   cond_ok = flag_z || (flag_n != flag_v);
      4'd14:   cond_ok = 1'b1;
      default: cond_ok = 1'b0;
    endcase
  end

  logic [31:0] imm_ext, shifted, offs_sum, ea;
  logic        upd;
  assign imm_ext  = {{(32-IMM_W){req_imm[IMM_W-1]}}, req_imm};
  assign shifted  = req_shr ? (req_rm >> req_shamt) : (req_rm << req_shamt);
  assign offs_sum = !req_use_reg ? req_base + imm_ext :
                    req_sub ? req_base - shifted : req_base + shifted;
  assign ea  = (req_mode == 2'd2) ? req_base :
               (req_mode == 2'd3) ? req_pc + imm_ext : offs_sum;
  assign upd = (req_mode == 2'd1) || (req_mode == 2'd2);

  logic [31:0]     a_q, nb_q, sd_q;
  logic            load_q, byte_q, upd_q;
  logic [RI_W-1:0] rd_q, rn_q;
  logic            accept, same_reg;

  assign accept   = req_valid && (st == S_IDLE);
  assign same_reg = (rd_q == rn_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      a_q    <= '0;
      nb_q   <= '0;
      sd_q   <= '0;
      load_q <= 1'b0;
      byte_q <= 1'b0;
      upd_q  <= 1'b0;
      rd_q   <= '0;
      rn_q   <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept && cond_ok) begin
          st     <= S_MEM;
          a_q    <= ea;
          nb_q   <= offs_sum;
          sd_q   <= req_sdata;
          load_q <= req_load;
          byte_q <= req_byte;
          upd_q  <= upd;
          rd_q   <= req_rd;
          rn_q   <= req_rn;
        end
        S_MEM: if (mem_ready)
          st <= load_q ? S_LDW : (upd_q ? S_BWB : S_IDLE);
        S_LDW: st <= (upd_q && !same_reg) ? S_BWB : S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [1:0]  lane;
  logic [31:0] ld_data;
  assign lane    = a_q[1:0];
  assign ld_data = byte_q ? {24'b0, mem_rdata[{lane, 3'b000} +: 8]} : mem_rdata;

  assign req_ready  = (st == S_IDLE);
  assign mem_valid  = (st == S_MEM);
  assign mem_we     = !load_q;
  assign mem_addr   = a_q;
  assign mem_be     = byte_q ? (4'b0001 << lane) : 4'b1111;
  assign mem_wdata  = byte_q ? {4{sd_q[7:0]}} : sd_q;
  assign rf_we      = (st == S_LDW) || (st == S_BWB);
  assign rf_waddr   = (st == S_LDW) ? rd_q : rn_q;
  assign rf_wdata   = (st == S_LDW) ? ld_data : nb_q;
  assign base_clash = (st == S_LDW) && upd_q && same_reg;

  AST_COND_FAIL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !cond_ok) |=> (req_ready && !mem_valid && !rf_we)); // R2
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr))); // R10
  AST_BYTE_LANE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we && byte_q) |-> ($countones(mem_be) == 1)); // R9
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid || rf_we) |-> !req_ready); // R13
  AST_CLASH_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    base_clash |=> (!rf_we && req_ready)); // R12
  AST_LOAD_THEN_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && !base_clash && load_q && upd_q && rf_waddr == rd_q) |=> (rf_we && rf_waddr == rn_q)); // R11

endmodule

// File: tb/ldst_cond_unit_tb.sv
`timescale 1ns/1ps
module ldst_cond_unit_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic req_valid = 0, req_ready;
  logic [3:0] req_cond = 4'd14;
  logic flag_n = 0, flag_z = 0, flag_c = 0, flag_v = 0;
  logic req_load = 0, req_byte = 0;
  logic [1:0] req_mode = 0;
  logic req_use_reg = 0, req_sub = 0, req_shr = 0;
  logic [4:0] req_shamt = 0;
  logic [11:0] req_imm = 0;
  logic [31:0] req_base = 0, req_rm = 0, req_pc = 0, req_sdata = 0;
  logic [3:0] req_rd = 0, req_rn = 0;
  logic mem_valid, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic [3:0] mem_be;
  logic rf_we, base_clash;
  logic [3:0] rf_waddr;
  logic [31:0] rf_wdata;

  ldst_cond_unit dut_i (.*);

  int errors = 0, checks = 0, stall = 0, wcnt = 0;
  logic [31:0] mem_word = 0;
  bit finished = 0;

  assign mem_ready = mem_valid && (wcnt >= stall);
  always @(posedge clk) begin
    if (mem_valid && mem_ready && !mem_we) mem_rdata <= mem_word;
    if (!mem_valid) wcnt <= 0;
    else if (!mem_ready) wcnt <= wcnt + 1;
  end

  int hs_n, wr_n, vcyc, addr_moves;
  logic [31:0] hs_addr, hs_wdata, last_addr;
  logic [3:0]  hs_be;
  logic        hs_we, clash_seen, prev_stall;
  logic [3:0]  wr_a [0:3];
  logic [31:0] wr_d [0:3];

  always @(negedge clk) begin
    if (mem_valid) begin
      vcyc++;
      if (prev_stall && mem_addr != last_addr) addr_moves++;
      last_addr = mem_addr;
    end
    prev_stall = mem_valid && !mem_ready;
    if (mem_valid && mem_ready) begin
      hs_n++; hs_addr = mem_addr; hs_we = mem_we; hs_wdata = mem_wdata; hs_be = mem_be;
    end
    if (rf_we) begin
      if (wr_n < 4) begin wr_a[wr_n] = rf_waddr; wr_d[wr_n] = rf_wdata; end
      wr_n++;
    end
    if (base_clash) clash_seen = 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic fire();
    hs_n = 0; wr_n = 0; vcyc = 0; addr_moves = 0; clash_seen = 0; prev_stall = 0;
    @(negedge clk) req_valid = 1;
    @(negedge clk) req_valid = 0;
    repeat (10) @(negedge clk);
  endtask

  task automatic set_op(input logic ld, input logic by, input logic [1:0] md, input logic [3:0] rd, input logic [3:0] rn);
    req_load = ld; req_byte = by; req_mode = md; req_rd = rd; req_rn = rn; req_cond = 4'd14;
  endtask

  function automatic bit exp_cond(input int c, input bit n, input bit z, input bit cy, input bit v);
    case (c)
      0: return z;   1: return !z;   2: return cy;  3: return !cy;
      4: return n;   5: return !n;   6: return v;   7: return !v;
      8: return cy && !z;  9: return !cy || z;
      10: return n == v;   11: return n != v;
      12: return !z && n == v;  13: return z || n != v;
      14: return 1;  default: return 0;
    endcase
  endfunction

  task automatic t_reset();
    chk(req_ready === 1'b1, "reset req_ready", req_ready, 1);
    chk(mem_valid === 1'b0, "reset mem_valid", mem_valid, 0);
    chk(rf_we === 1'b0, "reset rf_we", rf_we, 0);
  endtask

  task automatic t_cond();
    int bad = 0, badw = 0;
    set_op(0, 0, 2'd1, 4'd1, 4'd2);
    req_base = 32'h100; req_imm = 12'd4; req_use_reg = 0;
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++) begin
        req_cond = c[3:0];
        {flag_n, flag_z, flag_c, flag_v} = f[3:0];
        fire();
        if (hs_n != (exp_cond(c, f[3], f[2], f[1], f[0]) ? 1 : 0)) begin
          bad++;
          $display("FAIL R1 cond=%0d flags=%b handshakes actual=%0d expected=%0d", c, f[3:0], hs_n,
                   exp_cond(c, f[3], f[2], f[1], f[0]) ? 1 : 0);
        end
        if (!exp_cond(c, f[3], f[2], f[1], f[0]) && wr_n != 0) badw++;
      end
    chk(bad == 0, "R1 condition sweep", bad, 0);
    chk(badw == 0, "R2 failed condition writes", badw, 0);
    req_cond = 4'd15; fire();
    chk(hs_n == 0 && wr_n == 0, "R2 never code side effects", hs_n + wr_n, 0);
    chk(req_ready === 1'b1, "R2 ready after skip", req_ready, 1);
    req_cond = 4'd14;
  endtask

  task automatic t_pre();
    set_op(1, 0, 2'd0, 4'd3, 4'd4);
    req_base = 32'h1000; req_imm = 12'h7F8; req_use_reg = 0; mem_word = 32'hCAFE_0001;
    fire();
    chk(hs_addr == 32'h17F8, "R3 pre address", hs_addr, 32'h17F8);
    chk(wr_n == 1 && wr_a[0] == 4'd3, "R3 only load write", wr_n, 1);
    chk(wr_d[0] == 32'hCAFE_0001, "R8 word load data", wr_d[0], 32'hCAFE_0001);
  endtask

  task automatic t_prewb();
    set_op(0, 0, 2'd1, 4'd5, 4'd6);
    req_base = 32'h2000; req_imm = 12'hFF0; req_sdata = 32'h1234_5678;
    fire();
    chk(hs_addr == 32'h1FF0 && hs_we, "R4 pre-update address", hs_addr, 32'h1FF0);
    chk(wr_n == 1 && wr_a[0] == 4'd6 && wr_d[0] == 32'h1FF0, "R4 base update", wr_d[0], 32'h1FF0);
    chk(hs_be == 4'hF && hs_wdata == 32'h1234_5678, "R9 word store", hs_wdata, 32'h1234_5678);
    chk(wr_n == 1, "R7 immediate negative", wr_n, 1);
  endtask

  task automatic t_post_reg();
    set_op(0, 0, 2'd2, 4'd1, 4'd7);
    req_base = 32'h3000; req_use_reg = 1; req_rm = 32'h3; req_shamt = 5'd4; req_shr = 0; req_sub = 0;
    fire();
    chk(hs_addr == 32'h3000, "R5 post address", hs_addr, 32'h3000);
    chk(wr_n == 1 && wr_a[0] == 4'd7 && wr_d[0] == 32'h3030, "R5/R7 post update lsl add", wr_d[0], 32'h3030);
    set_op(0, 0, 2'd0, 4'd1, 4'd7);
    req_rm = 32'h800; req_shamt = 5'd3; req_shr = 1; req_sub = 1;
    fire();
    chk(hs_addr == 32'h2F00, "R7 lsr subtract", hs_addr, 32'h2F00);
    req_use_reg = 0; req_sub = 0; req_shr = 0;
  endtask

  task automatic t_pcrel();
    set_op(1, 0, 2'd3, 4'd2, 4'd2);
    req_pc = 32'h8000; req_imm = 12'hFFC; req_use_reg = 1; req_rm = 32'h40; req_base = 32'h5;
    fire();
    chk(hs_addr == 32'h7FFC, "R6 pc-relative address", hs_addr, 32'h7FFC);
    chk(wr_n == 1 && !clash_seen, "R6 no base write", wr_n, 1);
    req_use_reg = 0;
  endtask

  task automatic t_byte_load();
    mem_word = 32'hA1B2_C3D4;
    for (int k = 0; k < 4; k++) begin
      logic [31:0] e;
      set_op(1, 1, 2'd0, 4'd9, 4'd1);
      req_base = 32'h400; req_imm = 12'(k);
      fire();
      e = (mem_word >> (8 * k)) & 32'hFF;
      chk(wr_n == 1 && wr_d[0] == e, "R8 byte load lane", wr_d[0], e);
    end
  endtask

  task automatic t_byte_store();
    req_sdata = 32'h0000_005A;
    for (int k = 0; k < 4; k++) begin
      set_op(0, 1, 2'd0, 4'd9, 4'd1);
      req_base = 32'h500 + k; req_imm = 0;
      fire();
      chk(hs_be == (4'b1 << k), "R9 byte enable", hs_be, 4'b1 << k);
      chk(hs_wdata == 32'h5A5A_5A5A, "R9 byte replicate", hs_wdata, 32'h5A5A_5A5A);
    end
  endtask

  task automatic t_stall();
    set_op(1, 0, 2'd0, 4'd3, 4'd4);
    req_base = 32'h600; req_imm = 0; mem_word = 32'h0BAD_F00D; stall = 3;
    hs_n = 0; wr_n = 0; vcyc = 0; addr_moves = 0; clash_seen = 0; prev_stall = 0;
    @(negedge clk) req_valid = 1;
    @(negedge clk) req_valid = 0;
    chk(req_ready === 1'b0, "R13 busy ready low", req_ready, 0);
    repeat (12) @(negedge clk);
    chk(vcyc == 4 && addr_moves == 0, "R10 held request", vcyc, 4);
    chk(wr_n == 1 && wr_d[0] == 32'h0BAD_F00D, "R10 data after stall", wr_d[0], 32'h0BAD_F00D);
    stall = 0;
  endtask

  task automatic t_order();
    set_op(1, 0, 2'd2, 4'd8, 4'd9);
    req_base = 32'h700; req_imm = 12'h10; mem_word = 32'h5555_AAAA;
    fire();
    chk(wr_n == 2, "R11 write count", wr_n, 2);
    chk(wr_a[0] == 4'd8 && wr_d[0] == 32'h5555_AAAA, "R11 first write load", wr_d[0], 32'h5555_AAAA);
    chk(wr_a[1] == 4'd9 && wr_d[1] == 32'h710, "R11 second write base", wr_d[1], 32'h710);
  endtask

  task automatic t_clash();
    set_op(1, 0, 2'd1, 4'd6, 4'd6);
    req_base = 32'h900; req_imm = 12'h8; mem_word = 32'h7777_1111;
    fire();
    chk(wr_n == 1 && wr_d[0] == 32'h7777_1111, "R12 load wins", wr_d[0], 32'h7777_1111);
    chk(clash_seen == 1'b1, "R12 clash flagged", clash_seen, 1);
    chk(hs_addr == 32'h908, "R12 address", hs_addr, 32'h908);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_cond();
    t_pre();
    t_prewb();
    t_post_reg();
    t_pcrel();
    t_byte_load();
    t_byte_store();
    t_stall();
    t_order();
    t_clash();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule